// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block decides, for every memory access between 640 KB and 1 MB, whether the cycle is served by internal DRAM or passed to the external bus. It keeps a small route table, one 2-bit code for each upper-memory region plus one open/closed flag for the 128 KB system-management window. It fills that table from register-write events. Each event carries the register offset, the byte value before the write and the byte value after it. A region's code is reloaded only when that event shows its 4-bit field changing.

Routing is purely combinational from the access address, the direction and the latched table. Whenever an event alters a field, a one-cycle change pulse follows. A cache-flush controller can use it as its request. A status flag reports whether the top 64 KB of firmware space is shadowed for reads. A strap input selects which bit pattern of the system-management control byte opens the low window.

Top module: `shadow_attr_decode`

## Requirements
- R1: A region's 2-bit code routes independently by direction. Bit 0 set sends reads internal, and bit 1 set sends writes internal. So code 0 is fully external, 1 is reads-only internal, 2 is writes-only internal and 3 is fully internal.
- R2: Offset 0x59 bits [7:4] give the code for the 64 KB region 0xF0000–0xFFFFF, taken from bits [5:4]. Bits [3:0] of 0x59 control no region, and changing only them raises no pulse.
- R3: Offsets 0x5A–0x5F hold twelve 16 KB regions from 0xC0000 to 0xEFFFF, two per byte, with codes in bits [1:0] and [5:4]. The low nibble maps the lower-addressed region of the pair.
- R4: A region's code is reloaded only by an event at its offset whose old and new nibble differ. An event whose old and new nibble are equal leaves the table unchanged, even when the new value differs from the latched code.
- R5: With `smram_layout_new` high, the 0xA0000–0xBFFFF window is re-evaluated when event offset 0x72 changes bit 3 or bit 6. It becomes fully internal only if both bits are set in the new value, and fully external otherwise.
- R6: With `smram_layout_new` low, only bit 5 of offset 0x72 matters. Set makes the window fully internal, and clear makes it fully external. Bits 3 and 6 are ignored.
- R7: Any address below 0xA0000 routes internal in both directions.
- R8: `bios_shadowed` takes bit 4 of the new value whenever the upper nibble of offset 0x59 changes, and holds it otherwise.
- R9: `map_changed` is high for exactly the one cycle after an event that alters any region nibble or any relevant system-management bit. Events at other offsets give no pulse.
- R10: After reset every region and the window route external, `bios_shadowed` is 0 and `map_changed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smram_layout_new | input | 1 | Selects the two-bit (1) or one-bit (0) window enable pattern |
| ev_valid | input | 1 | Register-write event strobe |
| ev_off | input | 8 | Register offset of the event |
| ev_old | input | 8 | Byte value before the write |
| ev_new | input | 8 | Byte value after the write |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_internal | output | 1 | 1 = route to internal DRAM, 0 = external bus |
| bios_shadowed | output | 1 | Top-region shadow status |
| map_changed | output | 1 | One-cycle pulse on any attribute change |

## Verification
Accesses are swept across the first and last byte of each region with both directions. This separates read-only and write-only codes and exposes any swap of the low and high nibble within a byte. Events are sent where old and new nibbles are equal but differ from the latched code, which tells a change-gated reload apart from a plain copy of the new value. The window byte is exercised under both layouts with patterns that set only one of bits 3 and 6, and with bit 5 both set and clear. This shows that each layout ignores the other's enable bits.

// File: rtl/shadow_attr_decode.sv
module shadow_attr_decode #(
  parameter int          SEGS    = 12,
  parameter logic [7:0]  TOP_OFF = 8'h59,
  parameter logic [7:0]  SMM_OFF = 8'h72
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smram_layout_new,
  input  logic        ev_valid,
  input  logic [7:0]  ev_off,
  input  logic [7:0]  ev_old,
  input  logic [7:0]  ev_new,
  input  logic [19:0] acc_addr,
  input  logic        acc_write,
  output logic        acc_internal,
  output logic        bios_shadowed,
  output logic        map_changed
);
  localparam int          IW      = $clog2(SEGS);
  localparam logic [19:0] LOW_END = 20'hA0000;

  logic [SEGS-1:0][1:0] seg_code;
  logic [SEGS-1:0]      seg_hit;
  logic [1:0]           top_code;
  logic                 smm_open;

  for (genvar s = 0; s < SEGS; s++) begin : g_hit
    localparam logic [7:0] OFF = TOP_OFF + 8'(1 + s / 2);
    localparam int         LSB = (s % 2) * 4;
    assign seg_hit[s] = ev_valid && (ev_off == OFF) &&
                        (ev_old[LSB +: 4] != ev_new[LSB +: 4]);
  end

  wire       top_hit  = ev_valid && (ev_off == TOP_OFF) && (ev_old[7:4] != ev_new[7:4]);
  wire [7:0] smm_mask = smram_layout_new ? 8'h48 : 8'h20;
  wire       smm_hit  = ev_valid && (ev_off == SMM_OFF) && |((ev_old ^ ev_new) & smm_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_code      <= '0;
      top_code      <= 2'b00;
      smm_open      <= 1'b0;
      bios_shadowed <= 1'b0;
      map_changed   <= 1'b0;
    end else begin
      for (int s = 0; s < SEGS; s++)
        if (seg_hit[s]) seg_code[s] <= ev_new[(s % 2) * 4 +: 2];
      if (top_hit) begin
        top_code      <= ev_new[5:4];
        bios_shadowed <= ev_new[4];
      end
      if (smm_hit) smm_open <= ((ev_new & smm_mask) == smm_mask);
      map_changed <= top_hit | smm_hit | (|seg_hit);
    end
  end

  wire          in_low  = acc_addr < LOW_END;
  wire          in_smm  = acc_addr[19:17] == 3'b101;
  wire          in_top  = acc_addr[19:16] == 4'hF;
  wire [IW-1:0] seg_idx = acc_addr[14 +: IW];
  wire [1:0]    seg_sel = (seg_idx < IW'(SEGS)) ? seg_code[seg_idx] : 2'b00;
  wire [1:0]    code    = in_top ? top_code : seg_sel;

  assign acc_internal = in_low ? 1'b1 :
                        in_smm ? smm_open :
                        (acc_write ? code[1] : code[0]);

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    map_changed |-> $past(ev_valid)); // R9
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ev_valid) |-> ($stable(seg_code) && $stable(top_code) && $stable(smm_open))); // R4
  AST_LOW_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr < LOW_END) |-> acc_internal); // R7
  AST_BIOS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bios_shadowed) |-> $past(ev_valid && ev_off == TOP_OFF)); // R8
endmodule

// File: tb/shadow_attr_decode_test.sv
module shadow_attr_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smram_layout_new = 1'b1;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_off = '0, ev_old = '0, ev_new = '0;
  logic [19:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_internal, bios_shadowed, map_changed;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shadow_attr_decode uut (
    .clk(clk), .rst_n(rst_n), .smram_layout_new(smram_layout_new),
    .ev_valid(ev_valid), .ev_off(ev_off), .ev_old(ev_old), .ev_new(ev_new),
    .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_internal(acc_internal), .bios_shadowed(bios_shadowed),
    .map_changed(map_changed)
  );

  // {address, write, expected internal} after the setup writes below
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {20'hF0000, 1'b0, 1'b1}, {20'hFFFFF, 1'b1, 1'b0},  // R1 R2 code 1
    {20'hC0000, 1'b0, 1'b1}, {20'hC3FFF, 1'b1, 1'b1},  // R3 code 3
    {20'hC4000, 1'b0, 1'b0}, {20'hC7FFF, 1'b1, 1'b1},  // R1 R3 code 2
    {20'hC8000, 1'b0, 1'b0}, {20'hD0000, 1'b0, 1'b1},
    {20'hD0000, 1'b1, 1'b0}, {20'hD4000, 1'b0, 1'b0},
    {20'hEC000, 1'b0, 1'b1}, {20'hEFFFF, 1'b1, 1'b1},
    {20'hE8000, 1'b1, 1'b0}, {20'hA0000, 1'b0, 1'b1},  // R5 open
    {20'hBFFFF, 1'b1, 1'b1}, {20'h9FFFF, 1'b1, 1'b1},  // R7
    {20'h00000, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic route(string req, logic [19:0] a, logic w, logic exp);
    @(negedge clk);
    acc_addr = a; acc_write = w;
    #1 chk(req, acc_internal, exp);
  endtask

  task automatic event_wr(string req, logic [7:0] off, logic [7:0] o, logic [7:0] n, logic exp_pulse);
    @(negedge clk);
    ev_valid = 1'b1; ev_off = off; ev_old = o; ev_new = n;
    @(negedge clk);
    chk(req, map_changed, exp_pulse);
    ev_valid = 1'b0;
    @(negedge clk);
    chk("R9 width", map_changed, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    route("R10", 20'hF0000, 1'b0, 1'b0);
    route("R10", 20'hC0000, 1'b1, 1'b0);
    route("R10", 20'hA0000, 1'b0, 1'b0);
    chk("R10 bios", bios_shadowed, 1'b0);
    chk("R10 pulse", map_changed, 1'b0);

    event_wr("R9 R2", 8'h59, 8'h00, 8'h10, 1'b1);
    chk("R8", bios_shadowed, 1'b1);
    event_wr("R9 R3", 8'h5A, 8'h00, 8'h23, 1'b1);
    event_wr("R9 R3", 8'h5C, 8'h00, 8'h01, 1'b1);
    event_wr("R9 R3", 8'h5F, 8'h00, 8'h30, 1'b1);
    event_wr("R9 R5", 8'h72, 8'h02, 8'h4A, 1'b1);

    for (int i = 0; i < NV; i++)
      route("R1 R2 R3 R5 R7 table", VEC[i][21:2], VEC[i][1], VEC[i][0]);

    // R2 low nibble of 0x59 maps nothing
    event_wr("R2 low nibble", 8'h59, 8'h10, 8'h1F, 1'b0);
    route("R2", 20'hF0000, 1'b0, 1'b1);
    // R4 equal old/new nibbles do not reload
    event_wr("R4 stale", 8'h5B, 8'h33, 8'h33, 1'b0);
    route("R4", 20'hC8000, 1'b0, 1'b0);
    route("R4", 20'hCC000, 1'b1, 1'b0);
    // R9 unrelated offset
    event_wr("R9 other offset", 8'h60, 8'h00, 8'hFF, 1'b0);
    // R5 one of the two bits is not enough
    event_wr("R5", 8'h72, 8'h4A, 8'h0A, 1'b1);
    route("R5 bit3 only", 20'hA0000, 1'b0, 1'b0);
    event_wr("R5", 8'h72, 8'h0A, 8'h40, 1'b1);
    route("R5 bit6 only", 20'hB0000, 1'b1, 1'b0);
    // R6 older layout
    smram_layout_new = 1'b0;
    event_wr("R6", 8'h72, 8'h00, 8'h20, 1'b1);
    route("R6 open", 20'hA0000, 1'b1, 1'b1);
    event_wr("R6 ignore 3/6", 8'h72, 8'h20, 8'h68, 1'b0);
    route("R6 still open", 20'hBFFFF, 1'b0, 1'b1);
    event_wr("R6", 8'h72, 8'h20, 8'h48, 1'b1);
    route("R6 closed", 20'hA0000, 1'b0, 1'b0);
    // R8 status clears with top nibble
    event_wr("R9 R8", 8'h59, 8'h1F, 8'h0F, 1'b1);
    chk("R8 clear", bios_shadowed, 1'b0);
    route("R2 off", 20'hF8000, 1'b0, 1'b0);

    finish_run();
  end
endmodule